// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Word Receiver

This block takes one data word at a time from an outside producer that runs on a clock unrelated to the local one. The producer places a word on the data bus and raises a request line. The block waits for that request, takes in the word, and raises an acknowledge line. It keeps acknowledge high until the producer withdraws its request, then lowers acknowledge and waits for the next word. The request line is treated as a command coming in and acknowledge as a status going out. The block is always the passive party: it never starts a transfer.

The request line passes through a chain of synchroniser flops before the control state machine looks at it. The producer must keep the data bus stable from the moment it raises request until it sees acknowledge. The captured word stays in an internal register, and a one-cycle strobe tells the local logic that a new word has arrived. The local side has no ready signal and cannot push back. The strobe is a plain valid pulse, so the consumer must take `word_data` in the cycle the strobe is high or read it later from the held register. The word stays unchanged until the next capture.

Top module: `hs_word_receiver`

## Requirements
- R1: While `rst_n` is low, `ack_out` and `word_valid` are 0 and `word_data` is all zeros, and the block waits for a request.
- R2: While `req_in` stays low, changes on `data_in` have no effect: `word_valid` and `ack_out` stay 0 and `word_data` keeps its value.
- R3: A rise of `req_in` ahead of clock edge E0 drives `word_valid` high for exactly one cycle, from edge E0+2 to edge E0+3. No further strobe follows for that request.
- R4: In the cycle `word_valid` is high, `word_data` equals the value `data_in` held while the request was pending.
- R5: `ack_out` goes high one edge after the strobe (edge E0+3) and stays high for as long as the synchronised request stays high.
- R6: When `req_in` falls ahead of edge F0, `ack_out` stays high through edge F0+1 and is low from edge F0+2 on.
- R7: Changes on `data_in` while `ack_out` is high, and after acknowledge is released, do not alter `word_data`.
- R8: A new request raised in the same cycle that acknowledge falls is accepted with the same latency as the first, and its word is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 1 | Request from the producer, asynchronous to `clk` |
| data_in | input | DATA_W | Data bus from the producer, stable while request is high and acknowledge is low |
| ack_out | output | 1 | Acknowledge to the producer |
| word_valid | output | 1 | One-cycle strobe: a new word is in `word_data` |
| word_data | output | DATA_W | Last captured word, held until the next capture |

## Verification
Edges are counted from the first clock edge after `req_in` changes. The strobe and the new word are due two edges after that edge, acknowledge one edge later, and acknowledge falls two edges after the edge following the request's fall. The bench drives every input on a falling edge and then checks the outputs at each following falling edge. Each check names how many rising edges have passed, so early and late responses both fail, and so does a strobe that lasts longer than one cycle. Table-driven transfers vary the data pattern and how long the request is held. Directed cases cover idle data activity, back-to-back requests and a reset in the middle of a transfer.

// File: rtl/hs_rx_pkg.sv
package hs_rx_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_HI  = 2'd0,
    ST_CAPTURE  = 2'd1,
    ST_WAIT_LO  = 2'd2,
    ST_RELEASE  = 2'd3
  } hs_state_e;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic capture_en,
  output logic strobe,
  output logic ack
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_HI: if (req_s)  state_d = ST_CAPTURE;
      ST_CAPTURE:             state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (!req_s) state_d = ST_RELEASE;
      ST_RELEASE:             state_d = ST_WAIT_HI;
      default:                state_d = ST_WAIT_HI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_HI;
      ack     <= 1'b0;
    end else begin
      state_q <= state_d;
      ack     <= (state_d == ST_WAIT_LO);
    end
  end

  assign capture_en = (state_q == ST_WAIT_HI) && req_s;
  assign strobe     = (state_q == ST_CAPTURE);
endmodule

// File: rtl/hs_capture.sv
module hs_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/hs_word_receiver.sv
module hs_word_receiver #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack_out,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  logic req_s;
  logic capture_en;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (req_in),
    .sync_out (req_s)
  );

  hs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s      (req_s),
    .capture_en (capture_en),
    .strobe     (word_valid),
    .ack        (ack_out)
  );

  hs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (capture_en),
    .din   (data_in),
    .dout  (word_data)
  );
endmodule

// File: rtl/hs_rx_checker.sv
module hs_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_s,
  input logic              ack_out,
  input logic              word_valid,
  input logic [DATA_W-1:0] word_data
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!ack_out && !word_valid && word_data == '0));

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r5_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> ack_out);

  a_r5_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out && req_s) |=> ack_out);

  a_r6_release_needs_low_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_out) |-> !$past(req_s));

  a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(word_valid) |-> $stable(word_data));

  a_r2_no_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> !word_valid);
endmodule

bind hs_word_receiver hs_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_s      (req_s),
  .ack_out    (ack_out),
  .word_valid (word_valid),
  .word_data  (word_data)
);

// File: tb/test_hs_word_receiver.sv
module test_hs_word_receiver;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NVEC = 6;
  localparam logic [DW-1:0] VEC_DATA [NVEC] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
  localparam int            VEC_HOLD [NVEC] = '{0, 1, 3, 0, 5, 2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          req_in = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          ack_out;
  logic          word_valid;
  logic [DW-1:0] word_data;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_word_receiver #(.DATA_W(DW)) i_hs_word_receiver (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (req_in),
    .data_in    (data_in),
    .ack_out    (ack_out),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Request raised on a falling edge; rising edges then counted one by one.
  task automatic transfer(input logic [DW-1:0] d, input int hold);
    data_in = d;
    req_in  = 1'b1;
    for (int i = 1; i <= 2; i++) begin
      @(negedge clk);
      chk("R3", "strobe before edge 3", word_valid, 0);
      chk("R5", "ack before edge 3", ack_out, 0);
    end
    @(negedge clk);
    chk("R3", "strobe after edge 3", word_valid, 1);
    chk("R4", "captured word", word_data, d);
    chk("R5", "ack in strobe cycle", ack_out, 0);
    @(negedge clk);
    chk("R3", "strobe after edge 4", word_valid, 0);
    chk("R5", "ack after edge 4", ack_out, 1);
    for (int h = 0; h < hold; h++) begin
      data_in = ~d;
      @(negedge clk);
      chk("R5", "ack held with request", ack_out, 1);
      chk("R7", "word held under ack", word_data, d);
      chk("R3", "no second strobe", word_valid, 0);
    end
    req_in = 1'b0;
    for (int i = 1; i <= 2; i++) begin
      @(negedge clk);
      chk("R6", "ack before release edge", ack_out, 1);
    end
    @(negedge clk);
    chk("R6", "ack released", ack_out, 0);
    chk("R7", "word after release", word_data, d);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ack in reset", ack_out, 0);
    chk("R1", "strobe in reset", word_valid, 0);
    chk("R1", "word in reset", word_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: data activity with no request
    for (int i = 0; i < 6; i++) begin
      data_in = DW'(i * 37 + 3);
      @(negedge clk);
      chk("R2", "strobe while idle", word_valid, 0);
      chk("R2", "ack while idle", ack_out, 0);
      chk("R2", "word while idle", word_data, 0);
    end

    for (int v = 0; v < NVEC; v++) begin
      transfer(VEC_DATA[v], VEC_HOLD[v]);
      @(negedge clk);
    end

    // R8: second request raised as ack falls
    transfer(8'h3C, 0);
    transfer(8'hC3, 1);
    chk("R8", "back-to-back word", word_data, 8'hC3);

    // R7: data changes after release leave the word alone
    for (int i = 0; i < 3; i++) begin
      data_in = DW'(8'h10 + i);
      @(negedge clk);
      chk("R7", "word after later data change", word_data, 8'hC3);
    end

    // R1: reset in the middle of a transfer
    data_in = 8'h77;
    req_in  = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5", "ack up before reset", ack_out, 1);
    rst_n  = 1'b0;
    req_in = 1'b0;
    #1;
    chk("R1", "ack cleared by reset", ack_out, 0);
    chk("R1", "strobe cleared by reset", word_valid, 0);
    chk("R1", "word cleared by reset", word_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ack idle after reset", ack_out, 0);
    chk("R1", "strobe idle after reset", word_valid, 0);
    transfer(8'h42, 1);

    summary();
  end
endmodule